// File: doc/BRIEF.md
# Carrier Phase Error Detector

This block sits between a rectangular-to-polar converter and the loop filter of a carrier tracking loop. Each cycle that the converter presents a valid phase word, the block rotates it by a programmable phase offset and then scales it by a programmable power of two. The result is the phase error the loop filter consumes. The phase word is 8-bit two's complement, and its full scale stands for pi radians, so the word wraps naturally at plus and minus pi.

The offset is a 4-bit two's-complement fraction of pi, with a resolution of 22.5 degrees. It is added to the top four bits of the phase, modulo one full turn. The gain is a left shift of 0 to 3 places. It discards the bits pushed out of the top and fills the bottom with zeros. Both settings are static register inputs. The error word appears one clock after its phase sample, with its own valid strobe.

Top module: `carrier_phase_err_det`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state is err_out = 0 and err_vld = 0.
- R2: err_vld is high in the cycle after a cycle with phase_vld high and low in the cycle after a cycle with phase_vld low, which gives one cycle of latency.
- R3: The offset code, multiplied by 16, is added to the phase modulo 256. The four low phase bits therefore pass through unchanged, and the sum wraps instead of saturating (for example 0x90 plus code 0111 gives 0x00).
- R4: The offset code is read as two's complement in units of pi/8. Code 1000 adds -128 (that is, -pi), and code 0111 adds +112 (that is, +7pi/8).
- R5: The gain code g (0 to 3) shifts the offset sum left by g places. Bits above bit 7 are discarded, and the low g bits of err_out are zero.
- R6: In a cycle after phase_vld was low, err_out keeps its previous value.
- R7: With offset code 0000 and gain code 00, err_out equals the phase sample of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 8 | Phase sample, two's complement, full scale = pi |
| phase_vld | input | 1 | phase_in is valid this cycle |
| ofs_cfg | input | 4 | Phase offset code, two's complement in pi/8 steps |
| gain_cfg | input | 2 | Left-shift amount, 0 to 3 |
| err_out | output | 8 | Phase error word |
| err_vld | output | 1 | err_out carries a new result |

## Verification
The assertions check on every cycle the reset state, the one-cycle valid latency, the hold of the output when no sample arrives, the zero low bits left by the shift, the pass-through of the low phase bits when there is no shift, and the identity setting. The exact value of the modular sum, the two's-complement reading of the offset code and the truncation at the top of the shift are shown only by the bench. It sweeps every phase, offset and gain combination and adds hand-picked wrap points.

// File: rtl/phase_err_pkg.sv
// Package: shared defaults and helpers for the carrier phase error detector.
// Assumes the phase word and the offset code are both two's complement.
package phase_err_pkg;
    localparam int unsigned DEF_PHASE_W = 8;
    localparam int unsigned DEF_OFS_W   = 4;
    localparam int unsigned DEF_GAIN_W  = 2;

    // Mask of the low 'n' bits of a word of width w (w <= 32).
    function automatic logic [31:0] low_mask(input int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ped_offset_add.sv
// Module: ped_offset_add
// Adds a signed offset code to the top OFS_W bits of the phase word. The
// result wraps modulo a full turn. The offset code's MSB lines up with the
// phase sign bit, so the phase word's natural overflow is the 2pi wrap.
// Assumes OFS_W <= PHASE_W.
module ped_offset_add #(
    parameter int unsigned PHASE_W = 8,
    parameter int unsigned OFS_W   = 4
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [OFS_W-1:0]   ofs_i,
    output logic [PHASE_W-1:0] sum_o
);
    localparam int unsigned PAD_W = PHASE_W - OFS_W;

    logic [PHASE_W-1:0] ofs_aligned;

    // Place the offset code on the top bits and zero-fill below.
    generate
        if (PAD_W == 0) begin : g_full
            assign ofs_aligned = ofs_i;
        end else begin : g_pad
            assign ofs_aligned = {ofs_i, {PAD_W{1'b0}}};
        end
    endgenerate

    // Modular sum: the carry out of the top bit is dropped by the width.
    always_comb begin
        sum_o = phase_i + ofs_aligned;
    end
endmodule

// File: rtl/ped_gain_shift.sv
// Module: ped_gain_shift
// Applies a left shift of 0 to 2^GAIN_W-1 places as the detector gain. Bits
// shifted past the MSB are lost and the LSBs fill with zeros. It builds one
// candidate per shift amount and selects one by the gain code.
module ped_gain_shift #(
    parameter int unsigned PHASE_W = 8,
    parameter int unsigned GAIN_W  = 2
) (
    input  logic [PHASE_W-1:0] din_i,
    input  logic [GAIN_W-1:0]  gain_i,
    output logic [PHASE_W-1:0] dout_o
);
    localparam int unsigned N_SHIFT = 1 << GAIN_W;

    logic [PHASE_W-1:0] cand [N_SHIFT];

    // One truncating shifted copy per gain setting.
    generate
        for (genvar k = 0; k < N_SHIFT; k++) begin : g_cand
            if (k >= PHASE_W) begin : g_zero
                assign cand[k] = '0;
            end else begin : g_sh
                assign cand[k] = din_i << k;
            end
        end
    endgenerate

    // Select the candidate named by the gain code.
    always_comb begin
        dout_o = cand[gain_i];
    end
endmodule

// File: rtl/ped_out_reg.sv
// Module: ped_out_reg
// Output stage. It captures the error word when a sample is valid and keeps
// it otherwise. The valid strobe is delayed by one cycle. The synchronous
// active-low reset clears both.
module ped_out_reg #(
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] d_i,
    input  logic               vld_i,
    output logic [PHASE_W-1:0] q_o,
    output logic               vld_o
);
    // Register the error word on valid samples and hold it between them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (vld_i) begin
            q_o <= d_i;
        end
    end

    // Delay the valid strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (q_o == '0 && !vld_o)); // R1
    AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) vld_i |=> vld_o); // R2
    AST_VLD_FALL: assert property (@(posedge clk) disable iff (!rst_n) !vld_i |=> !vld_o); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !vld_i |=> $stable(q_o)); // R6
endmodule

// File: rtl/carrier_phase_err_det.sv
// Module: carrier_phase_err_det (top)
// Carrier phase error detector. It rotates an incoming phase word by a
// programmable offset, modulo 2pi, then scales it by a truncating left
// shift, and registers the result with one cycle of latency. Assumes the
// configuration inputs are quasi-static register outputs.
module carrier_phase_err_det
    import phase_err_pkg::*;
#(
    parameter int unsigned PHASE_W = DEF_PHASE_W,
    parameter int unsigned OFS_W   = DEF_OFS_W,
    parameter int unsigned GAIN_W  = DEF_GAIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               phase_vld,
    input  logic [OFS_W-1:0]   ofs_cfg,
    input  logic [GAIN_W-1:0]  gain_cfg,
    output logic [PHASE_W-1:0] err_out,
    output logic               err_vld
);
    localparam int unsigned LOW_W = PHASE_W - OFS_W;

    logic [PHASE_W-1:0] rot_sum;
    logic [PHASE_W-1:0] scaled;

    ped_offset_add #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_add (
        .phase_i (phase_in),
        .ofs_i   (ofs_cfg),
        .sum_o   (rot_sum)
    );

    ped_gain_shift #(.PHASE_W(PHASE_W), .GAIN_W(GAIN_W)) u_shift (
        .din_i  (rot_sum),
        .gain_i (gain_cfg),
        .dout_o (scaled)
    );

    ped_out_reg #(.PHASE_W(PHASE_W)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (scaled),
        .vld_i (phase_vld),
        .q_o   (err_out),
        .vld_o (err_vld)
    );

    AST_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |-> ((32'(err_out) & low_mask(32'($past(gain_cfg)))) == 32'd0)); // R5
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && $past(gain_cfg) == '0)
        |-> (err_out[LOW_W-1:0] == $past(phase_in[LOW_W-1:0]))); // R3
    AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && $past(gain_cfg) == '0 && $past(ofs_cfg) == '0)
        |-> (err_out == $past(phase_in))); // R7
endmodule

// File: tb/carrier_phase_err_det_tb_top.sv
`timescale 1ns/1ps
module carrier_phase_err_det_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] phase_in = '0;
    logic       phase_vld = 1'b0;
    logic [3:0] ofs_cfg = '0;
    logic [1:0] gain_cfg = '0;
    logic [7:0] err_out;
    logic       err_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    carrier_phase_err_det dut_i (
        .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .phase_vld(phase_vld),
        .ofs_cfg(ofs_cfg), .gain_cfg(gain_cfg), .err_out(err_out), .err_vld(err_vld)
    );

    function automatic int expect_err(int p, int o, int g);
        int off, s;
        off = (o >= 8) ? (o - 16) * 16 : o * 16;
        s = ((p + off) % 256 + 256) % 256;
        return (s * (1 << g)) % 256;
    endfunction

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one sample at a falling edge and check it at the next falling edge.
    task automatic sample(string tag, int p, int o, int g);
        phase_in = 8'(p); ofs_cfg = 4'(o); gain_cfg = 2'(g); phase_vld = 1'b1;
        @(negedge clk);
        cmp({tag, " vld"}, int'(err_vld), 1);
        cmp(tag, int'(err_out), expect_err(p, o, g));
    endtask

    // One idle cycle: the output must hold and the valid strobe must drop.
    task automatic idle(int prev);
        phase_vld = 1'b0; phase_in = 8'hA5; ofs_cfg = 4'h3; gain_cfg = 2'd1;
        @(negedge clk);
        cmp("R2 idle vld", int'(err_vld), 0);
        cmp("R6 hold", int'(err_out), prev);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 err_out", int'(err_out), 0);
        cmp("R1 err_vld", int'(err_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 code reading and R3 wrap points
        sample("R4 minus pi", 8'h00, 4'b1000, 0);
        sample("R4 plus 7pi/8", 8'h20, 4'b0111, 0);
        sample("R3 wrap", 8'h90, 4'b0111, 0);
        sample("R3 wrap neg", 8'h05, 4'b1000, 0);
        sample("R7 identity", 8'h7F, 0, 0);
        sample("R5 truncate", 8'hFF, 0, 3);
        idle(expect_err(8'hFF, 0, 3));
        // Exhaustive sweep: R3/R4/R5/R7 over every phase, offset and gain.
        for (int g = 0; g < 4; g++) begin
            for (int o = 0; o < 16; o++) begin
                for (int p = 0; p < 256; p++) begin
                    sample("R3/R4/R5 sweep", p, o, g);
                end
                idle(expect_err(255, o, g));
            end
        end
        // Reset during operation clears the output again (R1).
        sample("R7 before reset", 8'h33, 0, 0);
        rst_n = 1'b0; phase_vld = 1'b1;
        @(negedge clk);
        cmp("R1 mid err_out", int'(err_out), 0);
        cmp("R1 mid err_vld", int'(err_vld), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule